// File: doc/BRIEF.md
# Bit-Serial Secured Memory Card Controller

This block is the card-side logic of a bit-addressed serial memory card. The host drives three single-wire controls: a card clock, a card reset and a programme strobe. It also shares one data line with the card. The card keeps an internal bit pointer. At every falling edge of the card clock the pointer moves one bit forward, and the bit under the pointer is presented on the data line. No command words exist. The kind of operation follows from the edge of the card clock, the level of the strobe and the position of the pointer.

The bit array is divided into four equal zones. Each zone has its own read, write and erase enables, and selected zones can additionally require a valid key. The key is presented bit by bit. While the pointer sits inside the key field and the key has not yet been accepted, the card samples the data line instead of driving it. A write clears one bit. An erase sets every bit of the addressed byte. Both wait a programmable number of system clocks before they are allowed to complete.

All card pins are assumed to be already synchronous to the system clock `clk_i`. The power-on reset `rst_ni` is asynchronous and active-low. The bit array is held in registers. On power-on it is loaded with the deterministic stand-in pattern byte[i] = (37*i + 165) mod 256. Defaults: 2048 bits (`ADDR_W`=11), key field at bits 16 to 31.

Top module: `card_serial_mem`

## Requirements
- R1: After power-on reset the pointer is 0, the key is not accepted, `busy_o` is 0 and the array holds the stand-in pattern, so bit 0 (value 1) is driven with `io_oe_o` high.
- R2: A falling edge of `card_rst_i` while `card_clk_i` is low sets the pointer to 0 and leaves the key state unchanged. A falling edge of `card_rst_i` while `card_clk_i` is high has no effect.
- R3: Each falling edge of `card_clk_i` advances the pointer by one, except an edge that completes or aborts a programme operation. The pointer wraps from 2^ADDR_W-1 to 0.
- R4: When the addressed bit is readable, `io_oe_o` is 1 and `io_o` equals that bit. Bit address a maps to bit a mod 8 (LSB = 0) of byte a/8. The zone number is the top two pointer bits.
- R5: When the read is not allowed, `io_oe_o` is 0, so the pulled-up line reads 1. Reads are allowed in zones 0 and 1, in zone 2 only after the key is accepted, and never in zone 3.
- R6: Inside the key field (bits 16 to 31) while the key is not accepted, the card releases the line. It samples `io_i` at the rising edge of `card_clk_i` and compares the sample with the stored bit at the next falling edge.
- R7: The key is accepted only when all 16 key bits match in one ascending pass. Any mismatch blocks acceptance until power-on reset. Acceptance makes the key field readable and unlocks read, write and erase in zone 2.
- R8: A write is done in this order: `card_pgm_i` is high with 0 on `io_i` at the rising edge of `card_clk_i`, then `card_pgm_i` falls, then the delay runs, then the falling edge of `card_clk_i` arrives. It clears the addressed bit only in a write-enabled zone (zone 1, or zone 2 with the key).
- R9: The same sequence with 1 on `io_i` is an erase. It sets all eight bits of the addressed byte, only in an erase-enabled zone (zone 1, or zone 2 with the key).
- R10: The completing falling edge does not move the pointer. The new value of the addressed bit is then driven for verification.
- R11: `busy_o` is high from the falling edge of `card_pgm_i` until PROG_CYC system clocks have passed. A falling edge of `card_clk_i` before then aborts the operation and leaves the array unchanged.
- R12: When a qualifying reset edge and a clock falling edge arrive in the same cycle, the pointer becomes 0. The clock edge is then ignored, so there is no advance and no compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| card_clk_i | input | 1 | Card clock level |
| card_rst_i | input | 1 | Card reset level |
| card_pgm_i | input | 1 | Programme strobe level |
| io_i | input | 1 | Data line as seen by the card |
| io_o | output | 1 | Data the card drives |
| io_oe_o | output | 1 | Card drive enable; low means released (reads 1) |
| busy_o | output | 1 | Programming delay running |

## Verification
The card reset and the card clock falling edge can land in the same system cycle. One is a pointer clear and the other is an advance that may carry a key compare. The bench releases both pins on one system clock and judges the result by the next eight bits read back. These must spell the pattern starting at bit 0 (1,0,1,0,0,1,0,1) rather than a run starting one bit further on. A second overlap is a clock falling edge that lands while a programme delay is still counting. That edge is applied a few cycles after the strobe falls, and the bench expects the unchanged bit and no pointer advance.

// File: rtl/card_pkg.sv
package card_pkg;

  localparam int ZONES = 4;

  typedef enum logic {
    OP_WRITE = 1'b0,
    OP_ERASE = 1'b1
  } prog_op_e;

  // Stand-in contents loaded at power-on.
  function automatic logic [7:0] init_byte(input int idx);
    return 8'(idx * 37 + 165);
  endfunction

  // Access grant for one zone: opened by mask, optionally gated by the key.
  function automatic logic zone_allows(input logic [ZONES-1:0] open_mask,
                                       input logic [ZONES-1:0] lock_mask,
                                       input logic [1:0]       zone,
                                       input logic             key_ok);
    return open_mask[zone] & (~lock_mask[zone] | key_ok);
  endfunction

endpackage

// File: rtl/card_pin_sampler.sv
module card_pin_sampler #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] prev_o
);

  for (genvar g = 0; g < N; g++) begin : g_pin
    logic prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= pin_i[g];
    end
    assign prev_o[g] = prev_q;
  end

endmodule

// File: rtl/card_prog_timer.sv
module card_prog_timer #(
  parameter int PROG_CYC = 500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic clear_i,
  output logic busy_o,
  output logic ready_o
);

  localparam int CNT_W = $clog2(PROG_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (clear_i) begin
      cnt_d = '0;
      run_d = 1'b0;
    end else if (start_i) begin
      cnt_d = CNT_W'(PROG_CYC);
      run_d = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign busy_o  = run_q & (cnt_q != '0);
  assign ready_o = run_q & (cnt_q == '0);

endmodule

// File: rtl/card_key_check.sv
module card_key_check #(
  parameter int ADDR_W   = 11,
  parameter int KEY_BASE = 16,
  parameter int KEY_LEN  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cmp_evt_i,
  input  logic              match_i,
  output logic              in_field_o,
  output logic              key_ok_o
);

  localparam int RUN_W = $clog2(KEY_LEN + 1);

  logic [ADDR_W-1:0] idx;
  logic [RUN_W-1:0]  run_q, run_d;
  logic              bad_q, bad_d;
  logic              ok_q, ok_d;
  logic              in_order;

  assign in_field_o = (addr_i >= ADDR_W'(KEY_BASE)) &&
                      (addr_i <  ADDR_W'(KEY_BASE + KEY_LEN));
  assign idx        = addr_i - ADDR_W'(KEY_BASE);
  assign in_order   = (idx == ADDR_W'(run_q));

  always_comb begin
    run_d = run_q;
    bad_d = bad_q;
    ok_d  = ok_q;
    if (cmp_evt_i) begin
      if (!match_i) begin
        bad_d = 1'b1;
      end else if (in_order) begin
        run_d = run_q + 1'b1;
        if (!bad_q && (run_q == RUN_W'(KEY_LEN - 1))) ok_d = 1'b1;
      end else begin
        run_d = (idx == '0) ? RUN_W'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      bad_q <= 1'b0;
      ok_q  <= 1'b0;
    end else begin
      run_q <= run_d;
      bad_q <= bad_d;
      ok_q  <= ok_d;
    end
  end

  assign key_ok_o = ok_q;

endmodule

// File: rtl/card_serial_mem.sv
module card_serial_mem #(
  parameter int         ADDR_W   = 11,
  parameter int         PROG_CYC = 500000,
  parameter int         KEY_BASE = 16,
  parameter int         KEY_LEN  = 16,
  parameter logic [3:0] RD_OPEN  = 4'b0111,
  parameter logic [3:0] WR_OPEN  = 4'b0110,
  parameter logic [3:0] ER_OPEN  = 4'b0110,
  parameter logic [3:0] KEY_LOCK = 4'b0100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic card_clk_i,
  input  logic card_rst_i,
  input  logic card_pgm_i,
  input  logic io_i,
  output logic io_o,
  output logic io_oe_o,
  output logic busy_o
);

  import card_pkg::*;

  localparam int NBITS  = 1 << ADDR_W;
  localparam int NBYTES = NBITS / 8;
  localparam int BYTE_W = ADDR_W - 3;

  logic [2:0]        pins, prev;
  logic              clk_rise, clk_fall, clk_fall_eff, rst_evt, pgm_fall;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              armed_q, armed_d;
  prog_op_e          op_q, op_d;
  logic              sample_q, sample_d;
  logic [7:0]        mem_q [NBYTES];
  logic [BYTE_W-1:0] byte_idx;
  logic [2:0]        bit_idx;
  logic [1:0]        zone;
  logic [7:0]        cur_byte, wdata;
  logic              cur_bit, mem_we;
  logic              in_key, key_ok, cmp_mode, cmp_evt;
  logic              rd_ok, wr_ok, er_ok;
  logic              prog_ready, commit;

  assign pins = {card_pgm_i, card_rst_i, card_clk_i};

  card_pin_sampler #(.N(3)) u_pins (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pins),
    .prev_o(prev)
  );

  assign clk_rise     = card_clk_i & ~prev[0];
  assign clk_fall     = ~card_clk_i & prev[0];
  assign rst_evt      = ~card_rst_i & prev[1] & ~card_clk_i;
  assign pgm_fall     = ~card_pgm_i & prev[2];
  assign clk_fall_eff = clk_fall & ~rst_evt;

  assign byte_idx = addr_q[ADDR_W-1:3];
  assign bit_idx  = addr_q[2:0];
  assign zone     = addr_q[ADDR_W-1 -: 2];
  assign cur_byte = mem_q[byte_idx];
  assign cur_bit  = cur_byte[bit_idx];

  assign cmp_mode = in_key & ~key_ok;
  assign cmp_evt  = clk_fall_eff & ~armed_q & cmp_mode;
  assign rd_ok    = zone_allows(RD_OPEN, KEY_LOCK, zone, key_ok) & ~cmp_mode;
  assign wr_ok    = zone_allows(WR_OPEN, KEY_LOCK, zone, key_ok);
  assign er_ok    = zone_allows(ER_OPEN, KEY_LOCK, zone, key_ok);

  card_key_check #(
    .ADDR_W  (ADDR_W),
    .KEY_BASE(KEY_BASE),
    .KEY_LEN (KEY_LEN)
  ) u_key (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_q),
    .cmp_evt_i (cmp_evt),
    .match_i   (sample_q == cur_bit),
    .in_field_o(in_key),
    .key_ok_o  (key_ok)
  );

  card_prog_timer #(.PROG_CYC(PROG_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(armed_q & pgm_fall),
    .clear_i(clk_fall_eff & armed_q),
    .busy_o (busy_o),
    .ready_o(prog_ready)
  );

  assign commit = clk_fall_eff & armed_q & prog_ready;

  // Sequencing next state
  always_comb begin
    addr_d   = addr_q;
    armed_d  = armed_q;
    op_d     = op_q;
    sample_d = sample_q;
    if (rst_evt) begin
      addr_d = '0;
    end else if (clk_fall && !armed_q) begin
      addr_d = addr_q + 1'b1;
    end
    if (clk_fall_eff && armed_q) begin
      armed_d = 1'b0;
    end else if (clk_rise && card_pgm_i && !armed_q) begin
      armed_d = 1'b1;
      op_d    = io_i ? OP_ERASE : OP_WRITE;
    end
    if (clk_rise) sample_d = io_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      armed_q  <= 1'b0;
      op_q     <= OP_WRITE;
      sample_q <= 1'b0;
    end else begin
      addr_q   <= addr_d;
      armed_q  <= armed_d;
      op_q     <= op_d;
      sample_q <= sample_d;
    end
  end

  // Array update
  always_comb begin
    mem_we = 1'b0;
    wdata  = cur_byte;
    if (commit) begin
      if (op_q == OP_WRITE && wr_ok) begin
        mem_we = 1'b1;
        wdata  = cur_byte & ~(8'h01 << bit_idx);
      end else if (op_q == OP_ERASE && er_ok) begin
        mem_we = 1'b1;
        wdata  = 8'hFF;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NBYTES; i++) mem_q[i] <= init_byte(i);
    end else if (mem_we) begin
      mem_q[byte_idx] <= wdata;
    end
  end

  assign io_o    = cur_bit;
  assign io_oe_o = rd_ok & ~armed_q & ~card_pgm_i;

endmodule

// File: rtl/card_serial_mem_chk.sv
module card_serial_mem_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clk_fall,
  input logic              rst_evt,
  input logic              armed_q,
  input logic [ADDR_W-1:0] addr_q,
  input logic              key_ok,
  input logic              cmp_mode,
  input logic              busy_o,
  input logic              io_oe_o
);

  // R3: plain clock falls step the pointer by one, wrapping
  assert_addr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_fall && !rst_evt && !armed_q) |=> ((addr_q - $past(addr_q)) == ADDR_W'(1)));

  // R2 and R12: a qualifying reset edge clears the pointer
  assert_card_reset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_evt |=> (addr_q == '0));

  // R10: the edge that ends a programme operation keeps the pointer
  assert_prog_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_fall && armed_q && !rst_evt) |=> $stable(addr_q));

  // R7: key acceptance never drops before power-on reset
  assert_key_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_ok |=> key_ok);

  // R11: delay only runs for an armed operation
  assert_busy_armed_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> armed_q);

  // R6: line released while comparing key bits
  assert_cmp_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_mode |-> !io_oe_o);

endmodule

bind card_serial_mem card_serial_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .clk_fall(clk_fall),
  .rst_evt (rst_evt),
  .armed_q (armed_q),
  .addr_q  (addr_q),
  .key_ok  (key_ok),
  .cmp_mode(cmp_mode),
  .busy_o  (busy_o),
  .io_oe_o (io_oe_o)
);

// File: tb/card_serial_mem_tb.sv
module card_serial_mem_tb;

  localparam int ADDR_W = 11;
  localparam int NB     = 1 << ADDR_W;
  localparam int PCYC   = 20;
  localparam int KB     = 16;
  localparam int KL     = 16;

  logic clk, rst_n, card_clk, card_rst, card_pgm, card_io;
  logic io_o, io_oe_o, busy_o, line;

  card_serial_mem #(.ADDR_W(ADDR_W), .PROG_CYC(PCYC)) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .card_clk_i(card_clk),
    .card_rst_i(card_rst),
    .card_pgm_i(card_pgm),
    .io_i      (card_io),
    .io_o      (io_o),
    .io_oe_o   (io_oe_o),
    .busy_o    (busy_o)
  );

  assign line = io_oe_o ? io_o : 1'b1;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int unsigned n_chk = 0, n_err = 0;
  bit          done  = 0;
  logic [7:0]  m_mem [NB/8];
  int          m_addr, m_run;
  bit          m_key, m_bad;

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic got, input logic exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s addr=%0d got=%0b exp=%0b", tag, m_addr, got, exp);
    end
  endtask

  function automatic bit mbit(input int a);
    return m_mem[a / 8][a % 8];
  endfunction

  function automatic bit in_cmp(input int a);
    return (a >= KB) && (a < KB + KL) && !m_key;
  endfunction

  function automatic bit readable(input int a);
    int z = a >> (ADDR_W - 2);
    if (in_cmp(a)) return 0;
    if (z == 0 || z == 1) return 1;
    if (z == 2) return m_key;
    return 0;
  endfunction

  function automatic bit may_change(input int a);
    int z = a >> (ADDR_W - 2);
    return (z == 1) || (z == 2 && m_key);
  endfunction

  function automatic bit exp_line(input int a);
    return readable(a) ? mbit(a) : 1'b1;
  endfunction

  function automatic string tag_of(input int a);
    if (a == 0) return "R3";
    if (in_cmp(a)) return "R6";
    if (!readable(a)) return "R5";
    return "R4";
  endfunction

  task automatic por();
    rst_n = 0; card_clk = 0; card_rst = 0; card_pgm = 0; card_io = 1;
    w(3);
    rst_n = 1;
    w(2);
    for (int i = 0; i < NB / 8; i++) m_mem[i] = 8'(i * 37 + 165);
    m_addr = 0; m_run = 0; m_key = 0; m_bad = 0;
  endtask

  task automatic pulse(input bit corrupt, input string tag);
    int a    = m_addr;
    bit cm   = in_cmp(a);
    card_io  = cm ? (mbit(a) ^ corrupt) : 1'b1;
    card_clk = 1;
    w(2);
    card_clk = 0;
    w(2);
    card_io  = 1;
    if (cm) begin
      if (corrupt) m_bad = 1;
      else if (a - KB == m_run) begin
        m_run++;
        if (m_run == KL && !m_bad) m_key = 1;
      end else m_run = (a == KB) ? 1 : 0;
    end
    m_addr = (a + 1) % NB;
    chk(line, exp_line(m_addr), (tag == "") ? tag_of(m_addr) : tag);
  endtask

  task automatic card_reset();
    card_rst = 1; w(2);
    card_rst = 0; w(2);
    m_addr = 0;
    chk(line, exp_line(0), "R2");
  endtask

  task automatic go_to(input int t);
    if (t < m_addr) card_reset();
    while (m_addr != t) pulse(0, "");
  endtask

  task automatic prog(input bit val, input bit early, input string tag);
    card_io = val; card_pgm = 1; w(2);
    card_clk = 1; w(2);
    card_pgm = 0; w(3);
    chk(busy_o, 1'b1, "R11 busy during delay");
    if (!early) w(PCYC + 2);
    card_clk = 0; w(2);
    card_io = 1;
    if (!early && may_change(m_addr)) begin
      if (val == 0) m_mem[m_addr / 8][m_addr % 8] = 1'b0;
      else          m_mem[m_addr / 8] = 8'hFF;
    end
    chk(line, exp_line(m_addr), tag);
    chk(busy_o, 1'b0, "R11 busy after end");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    por();
    // R1: reset state
    chk(io_oe_o, 1'b1, "R1 oe");
    chk(line, 1'b1, "R1 bit0");
    chk(busy_o, 1'b0, "R1 busy");

    // Pass with a wrong key bit, full wrap (R3, R4, R5, R6)
    for (int k = 0; k < NB; k++) pulse(m_addr == 20, "");
    // Second pass with the right key: still blocked (R7)
    go_to(24);
    chk(io_oe_o, 1'b0, "R7 key stays rejected");
    go_to(40);
    chk(m_key, 1'b0, "R7 model");

    // Fresh power-on, correct key this time
    por();
    chk(line, 1'b1, "R1 bit0 again");
    go_to(10);
    card_reset();
    for (int k = 0; k < 8; k++) pulse(0, "R2 after card reset");
    go_to(12);
    // R2: reset edge while clock high is ignored
    card_clk = 1; w(2);
    card_rst = 1; w(2);
    card_rst = 0; w(2);
    card_clk = 0; w(2);
    m_addr = 13;
    chk(line, exp_line(13), "R2 ignored when clock high");
    go_to(40);
    chk(m_key, 1'b1, "R7 model accept");
    go_to(20);
    chk(io_oe_o, 1'b1, "R7 key field readable");
    go_to(45);
    // R12: coincident reset and clock falling edge
    card_rst = 1; card_clk = 1; w(2);
    card_rst = 0; card_clk = 0; w(2);
    m_addr = 0;
    chk(line, exp_line(0), "R12");
    for (int k = 0; k < 8; k++) pulse(0, "R12 sequence");

    // Directed programme operations
    go_to(40);   prog(1, 0, "R9 erase blocked zone0");
    go_to(41);   prog(0, 0, "R8 write blocked zone0");
    pulse(0, "R10 next bit after prog");
    go_to(520);  prog(1, 0, "R9 erase zone1 R10");
    pulse(0, "R9 byte filled");
    prog(0, 0, "R8 write zone1 R10");
    go_to(528);  prog(1, 1, "R11 abort keeps data");
    pulse(0, "R11 pointer after abort");
    go_to(1040); prog(0, 0, "R8 write zone2 keyed");
    go_to(1041); prog(1, 0, "R9 erase zone2 keyed");
    for (int k = 0; k < 8; k++) pulse(0, "R9 zone2 byte");

    // Constrained random programme operations
    for (int k = 0; k < 10; k++) begin
      int t  = int'($urandom_range(1535, 32));
      int op = int'($urandom_range(2, 0));
      go_to(t);
      case (op)
        0:       prog(0, 0, "R8 random write");
        1:       prog(1, 0, "R9 random erase");
        default: prog(1'($urandom_range(1, 0)), 1, "R11 random abort");
      endcase
      for (int j = 0; j < 4; j++) pulse(0, "");
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule